// File: doc/BRIEF.md
# Elastic FIFO with Bypassing Output Stage

This block is a single-clock ready/valid queue for on-chip network links. Its storage is a bank of parallel slot registers. A one-hot tail ring writes the bank and a one-hot head ring reads it, so neither pointer needs an adder. A two-entry elastic stage follows the bank. Its registers drive the downstream port, which keeps the wide read multiplexer of the bank off the output timing path.

When the queue holds nothing, an accepted word skips the bank and lands directly in the output stage. Words go into the bank only when the output stage cannot take them. The stage refills from the bank head whenever it has room, so the bank soaks up bursts while the receiver stalls, and arrival order is kept.

The upstream `in_ready` comes only from registered occupancy. It has no combinational path from `out_ready`. Total capacity is `DEPTH + 2` words: `DEPTH` bank slots plus the two stage slots.

Top module: `elastic_out_fifo`

## Requirements
- R1: After synchronous active-low reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Words leave in exactly the order they were accepted, with none lost or repeated. A word is accepted when `in_valid` and `in_ready` are both 1 at a clock edge, and it leaves when `out_valid` and `out_ready` are both 1 at a clock edge.
- R3: `in_ready` is 0 exactly when the queue holds `DEPTH + 2` words, and 1 otherwise.
- R4: `out_valid` is 1 exactly when the queue holds at least one word, and `out_data` is then the oldest word held.
- R5: A word accepted while the queue is empty appears on `out_valid`/`out_data` in the very next cycle.
- R6: `in_ready` does not change when `out_ready` changes within a cycle.
- R7: The head and tail pointers are each one-hot at all times. Each moves by one slot, with wrap-around, only on a bank read or a bank write respectively. Ordering holds across many wraps.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Upstream word present |
| in_ready | output | 1 | Queue can accept a word |
| in_data | input | DW | Upstream word |
| out_valid | output | 1 | Oldest word present on `out_data` |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | DW | Oldest held word |

## Verification
The two functions that can fall in the same cycle are an upstream accept and a downstream take. That includes the case where a take drains the stage while a new word bypasses into it, and the case where a bank read refills the stage while a bank write lands at the tail. Random valid and ready densities are swept from sparse to saturated, so the two coincide at every occupancy from empty to one short of full. A behavioural queue in the bench predicts `in_ready`, `out_valid` and `out_data` every cycle. `out_ready` is also toggled mid-cycle to show that `in_ready` does not move.

// File: rtl/efifo_pkg.sv
// Shared types for the elastic FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package efifo_pkg;
    // Where an accepted input word is steered this cycle.
    typedef enum logic [1:0] {
        ROUTE_NONE  = 2'd0,
        ROUTE_STAGE = 2'd1,
        ROUTE_BANK  = 2'd2
    } route_e;
endpackage

// File: rtl/ring_ptr.sv
// One-hot ring pointer: rotates left by one slot per advance, wrapping.
// Assumes: N >= 2; reset selects slot 0.
module ring_ptr #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [N-1:0] ptr
);
    // Rotate the single hot bit on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= N'(1);
        else if (adv) ptr <= {ptr[N-2:0], ptr[N-1]};
    end

    a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(ptr));
    a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr));
endmodule

// File: rtl/slot_bank.sv
// Parallel slot registers: write at one-hot wsel, AND-OR read at one-hot rsel.
// Assumes: wsel/rsel are one-hot; a read of the slot being written sees the old word.
module slot_bank #(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             wr,
    input  logic [DEPTH-1:0] wsel,
    input  logic [DW-1:0]    wdata,
    input  logic [DEPTH-1:0] rsel,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] slot [DEPTH];
    logic [DW-1:0] masked [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Capture the input word into the selected slot.
        always_ff @(posedge clk) begin
            if (wr && wsel[g]) slot[g] <= wdata;
        end
        assign masked[g] = rsel[g] ? slot[g] : '0;
    end

    // OR together the masked slots to form the read word.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) rdata = rdata | masked[i];
    end
endmodule

// File: rtl/out_stage2.sv
// Two-entry elastic output stage; front entry drives the port from a register.
// Assumes: at most one enqueue per cycle; enq only when a slot is free after deq.
module out_stage2 #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enq,
    input  logic [DW-1:0] din,
    input  logic          deq,
    output logic          valid,
    output logic [DW-1:0] dout,
    output logic [1:0]    cnt
);
    logic [DW-1:0] s0, s1, s0_n, s1_n;
    logic [1:0]    after_deq;

    // Shift on dequeue, then place the new word behind what remains.
    always_comb begin
        after_deq = cnt - {1'b0, deq};
        s0_n = deq ? s1 : s0;
        s1_n = s1;
        if (enq) begin
            if (after_deq == 2'd0) s0_n = din;
            else                   s1_n = din;
        end
    end

    // Register entries and entry count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 2'd0;
            s0  <= '0;
            s1  <= '0;
        end else begin
            cnt <= after_deq + {1'b0, enq};
            s0  <= s0_n;
            s1  <= s1_n;
        end
    end

    assign valid = (cnt != 2'd0);
    assign dout  = s0;

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !deq |=> valid && $stable(dout));
    a_r3_stage_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        enq |-> (cnt != 2'd2) || deq);
endmodule

// File: rtl/elastic_out_fifo.sv
// Ready/valid FIFO: parallel slot bank with one-hot rings, plus a bypassable
// two-entry output stage. in_ready depends only on registered occupancy.
// Assumes: single clock, synchronous active-low reset, DEPTH >= 2.
module elastic_out_fifo
    import efifo_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] SC_FULL = CW'(DEPTH);

    logic [CW-1:0]    sc;
    logic [1:0]       oc;
    logic             push, pop, room, bank_empty, refill, bank_wr, stage_enq;
    logic [DEPTH-1:0] head, tail;
    logic [DW-1:0]    bank_rd, stage_din;
    route_e           route;

    assign in_ready   = !((oc == 2'd2) && (sc == SC_FULL));
    assign push       = in_valid && in_ready;
    assign pop        = out_valid && out_ready;
    assign room       = (oc != 2'd2) || pop;
    assign bank_empty = (sc == '0);
    assign refill     = !bank_empty && room;

    // Steer an accepted word: straight to the stage only when the bank is empty.
    always_comb begin
        if (!push)                    route = ROUTE_NONE;
        else if (bank_empty && room)  route = ROUTE_STAGE;
        else                          route = ROUTE_BANK;
    end

    assign bank_wr   = (route == ROUTE_BANK);
    assign stage_enq = refill || (route == ROUTE_STAGE);
    assign stage_din = refill ? bank_rd : in_data;

    // Track the number of words held in the bank.
    always_ff @(posedge clk) begin
        if (!rst_n) sc <= '0;
        else        sc <= sc + CW'(bank_wr) - CW'(refill);
    end

    ring_ptr #(.N(DEPTH)) u_tail (.clk(clk), .rst_n(rst_n), .adv(bank_wr), .ptr(tail));
    ring_ptr #(.N(DEPTH)) u_head (.clk(clk), .rst_n(rst_n), .adv(refill),  .ptr(head));

    slot_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
        .clk(clk), .wr(bank_wr), .wsel(tail), .wdata(in_data),
        .rsel(head), .rdata(bank_rd)
    );

    out_stage2 #(.DW(DW)) u_stage (
        .clk(clk), .rst_n(rst_n), .enq(stage_enq), .din(stage_din),
        .deq(pop), .valid(out_valid), .dout(out_data), .cnt(oc)
    );

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |-> sc != SC_FULL);
    a_r2_bank_behind_full_stage: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_empty |-> oc == 2'd2);
    a_r5_bypass_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        push && bank_empty && oc == 2'd0 |=> out_valid && out_data == $past(in_data));
    a_r7_ptrs_meet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        bank_empty |-> head == tail);
endmodule

// File: tb/elastic_out_fifo_tb.sv
module elastic_out_fifo_tb;
    localparam int DW = 16;
    localparam int DEPTH = 4;
    localparam int CAP = DEPTH + 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic in_ready, out_valid;
    logic [DW-1:0] out_data;

    int checks = 0, fails = 0;
    logic [DW-1:0] q[$];
    int seq = 0, next_out = 0, pushes = 0, pops = 0;
    bit done = 0;

    always #2 clk = ~clk;

    elastic_out_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive (at posedge+1), probe R6, compare at negedge, update model at posedge.
    task automatic step(input int pv, input int pr);
        bit exp_v, exp_r, r_a, r_b;
        logic hold_v;
        logic [DW-1:0] hold_d;
        if (!(in_valid && !in_ready)) begin
            in_valid = ($urandom_range(99) < pv);
            if (in_valid) begin in_data = DW'(seq); end
        end
        out_ready = ($urandom_range(99) < pr);
        #0.25 r_a = in_ready;
        out_ready = ~out_ready;
        #0.25 r_b = in_ready;
        out_ready = ~out_ready;
        chk(r_a == r_b, "R6 in_ready vs out_ready", int'(r_b), int'(r_a));
        @(negedge clk);
        exp_v = (q.size() > 0);
        exp_r = (q.size() < CAP);
        chk(out_valid == exp_v, "R4 out_valid", int'(out_valid), int'(exp_v));
        chk(in_ready == exp_r, "R3 in_ready", int'(in_ready), int'(exp_r));
        if (exp_v) chk(out_data == q[0], "R4 out_data oldest", int'(out_data), int'(q[0]));
        hold_v = out_valid && !out_ready;
        hold_d = out_data;
        @(posedge clk);
        if (exp_v && out_ready) begin
            chk(int'(q[0]) == next_out, "R2 order/no loss", int'(q[0]), next_out);
            void'(q.pop_front());
            next_out++;
            pops++;
        end
        if (in_valid && exp_r) begin
            q.push_back(in_data);
            seq++;
            pushes++;
        end
        #1;
        if (hold_v) begin
            chk(out_valid == 1'b1, "R8 valid held", int'(out_valid), 1);
            chk(out_data == hold_d, "R8 data held", int'(out_data), int'(hold_d));
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
        @(posedge clk); #1;

        // R5: single word into empty queue, receiver stalled.
        step(100, 0);
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b1, "R5 bypass latency", int'(out_valid), 1);
        chk(out_data == q[0], "R5 bypass data", int'(out_data), int'(q[0]));
        @(posedge clk); #1;

        // R3: fill to capacity with receiver stalled.
        repeat (CAP + 3) step(100, 0);
        @(negedge clk);
        chk(in_ready == 1'b0, "R3 full blocks", int'(in_ready), 0);
        chk(q.size() == CAP, "R3 capacity", q.size(), CAP);
        @(posedge clk); #1;

        // Sweep densities so accept and take coincide at every occupancy.
        for (int pv = 10; pv <= 100; pv += 30)
            for (int pr = 10; pr <= 100; pr += 30)
                repeat (300) step(pv, pr);

        // Drain.
        in_valid = 1'b0;
        repeat (CAP + 4) step(0, 100);
        chk(pops == pushes, "R2 nothing lost", pops, pushes);
        chk(pops > 8 * DEPTH, "R7 many pointer wraps", pops, 8 * DEPTH);
        @(negedge clk);
        chk(out_valid == 1'b0, "R4 empty after drain", int'(out_valid), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule